// File: doc/BRIEF.md
# Banked GPIO Port with Masked Writes

A 32-pin general-purpose I/O bank organised as four ports of eight pins. Each port carries a set of byte-wide registers: GPIO-mode enable, output enable, output value, synchronised input value, interrupt status, interrupt enable, a 24-bit interrupt trigger type, and a write-only interrupt clear. Software reaches them over a single-cycle register bus. Writes take effect at the clock edge. Read data is combinational from the address.

Every register except input and clear has a second "masked" alias. A write to the alias changes only the pins named in a select byte, so one pin can be changed without a read-modify-write. Pad inputs pass through a two-flop synchroniser. They then feed per-pin detectors for high level, low level, rising edge, falling edge and both edges. The enabled pending pins of all four ports are ORed into one interrupt line.

Top module: `gpio_bank32`

## Requirements
- R1: After the asynchronous reset, configuration, output enable, output, interrupt enable and trigger type all read zero, `pad_oe_o` is zero and `irq_o` is low.
- R2: Address decoding:
  - bits 3:2 select the port.
  - bits 6:4 select the group: 0 mode enable, 1 output enable, 2 output, 3 input, 4 status, 5 interrupt enable, 6 trigger type, 7 clear.
  - bit 7 selects the masked alias.
  - A plain write loads data bits 7:0, or bits 23:0 for trigger type.
  - Reads are zero-extended, and clear reads zero.
- R3: A masked write to mode enable, output enable, output or interrupt enable changes only the pins whose bit in data 15:8 is 1. Those pins take the matching bit of data 7:0. A read of a masked alias returns the plain register value.
- R4: `pad_oe_o` for a pin is its mode-enable bit AND its output-enable bit. `pad_out_o` mirrors the output register.
- R5: The input group returns the pad value after two clocks of synchronisation. Writes to it through either alias are ignored.
- R6: The trigger type register has three bit planes:
  - Bit n is polarity (1 = high or rising). Bit n+8 selects edge mode. Bit n+16 selects both edges when edge mode is on.
  - In edge mode without both edges, polarity 1 means rising and 0 means falling.
  - A masked write to trigger type updates only the polarity plane.
- R7: In level mode the status bit is 1 exactly when the synchronised pin equals its polarity, one clock after the synchroniser. A clear therefore has no lasting effect while the level holds.
- R8: In edge mode a matching edge sets the status bit. The bit stays set after the pin returns, until it is cleared. A pad change shows in status three clocks after it is sampled.
- R9: A plain write to the clear group clears the status of each edge-mode pin whose data bit is 1. Zero bits have no effect, and a write to the clear group's masked alias is ignored.
- R10: If a clear and a new matching edge hit the same pin in the same cycle, the status bit ends up set.
- R11: A plain write to the status group is ignored. A masked status write sets or clears the selected edge-mode pins.
- R12: `irq_o` is high when any pin of any port has both status and interrupt enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register byte address |
| reg_we_i | input | 1 | Write strobe, applied at the clock edge |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| pad_in_i | input | 32 | Pad input levels, asynchronous |
| pad_out_o | output | 32 | Pad output values |
| pad_oe_o | output | 32 | Pad output enables |
| irq_o | output | 1 | Bank interrupt |

## Verification
Assertions inside each port check four properties on every cycle:
- A masked output write leaves unselected pins unchanged.
- A clear with no coincident edge always drops an edge-mode status bit.
- A detected edge always leaves the status set, whatever clear arrives with it.
- A level-mode status always tracks the active level of the previous cycle.

The bench's directed scenarios show the rest:
- the exact latency from pad to status and interrupt;
- that writes to input, plain status and the masked clear alias are ignored;
- the trigger-type decoding of each mode, and that a masked type write touches only polarity;
- that the interrupt OR spans ports.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int GRP_W = 3;

  typedef enum logic [GRP_W-1:0] {
    GRP_CNF = 3'd0,
    GRP_OE  = 3'd1,
    GRP_OUT = 3'd2,
    GRP_IN  = 3'd3,
    GRP_STA = 3'd4,
    GRP_ENB = 3'd5,
    GRP_TYP = 3'd6,
    GRP_CLR = 3'd7
  } grp_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter  int PINS = 8,
  localparam int TW   = 3 * PINS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic            msk_i,
  input  grp_e            grp_i,
  input  logic [TW-1:0]   wdata_i,
  input  logic [PINS-1:0] pin_i,
  output logic [PINS-1:0] cnf_o,
  output logic [PINS-1:0] oe_o,
  output logic [PINS-1:0] out_o,
  output logic [PINS-1:0] sta_o,
  output logic [PINS-1:0] enb_o,
  output logic [TW-1:0]   typ_o,
  output logic            pend_o
);
  logic [PINS-1:0] cnf_q, oe_q, out_q, sta_q, enb_q, prev_q;
  logic [TW-1:0]   typ_q;
  logic [PINS-1:0] sel, val, pol, edge_m, both, rise, fall, evt, act, clr, sta_d;
  logic            sta_w;

  assign sel = wdata_i[2*PINS-1:PINS];
  assign val = wdata_i[PINS-1:0];

  function automatic logic [PINS-1:0] merge(input logic [PINS-1:0] old,
                                            input logic [PINS-1:0] s,
                                            input logic [PINS-1:0] v,
                                            input logic            m);
    return m ? ((old & ~s) | (v & s)) : v;
  endfunction

  // trigger planes: polarity, edge mode, both edges
  assign pol    = typ_q[PINS-1:0];
  assign edge_m = typ_q[2*PINS-1:PINS];
  assign both   = typ_q[TW-1:2*PINS];

  assign rise = pin_i & ~prev_q;
  assign fall = ~pin_i & prev_q;
  assign evt  = (both & (rise | fall)) | (~both & pol & rise) | (~both & ~pol & fall);
  assign act  = ~(pin_i ^ pol);

  assign clr   = (wr_i && grp_i == GRP_CLR && !msk_i) ? val : '0;
  assign sta_w = wr_i && grp_i == GRP_STA && msk_i;

  always_comb begin
    for (int n = 0; n < PINS; n++) begin
      if (!edge_m[n])             sta_d[n] = act[n];
      else if (evt[n])            sta_d[n] = 1'b1;  // new edge beats clear
      else if (clr[n])            sta_d[n] = 1'b0;
      else if (sta_w && sel[n])   sta_d[n] = val[n];
      else                        sta_d[n] = sta_q[n];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnf_q  <= '0;
      oe_q   <= '0;
      out_q  <= '0;
      enb_q  <= '0;
      sta_q  <= '0;
      typ_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= pin_i;
      sta_q  <= sta_d;
      if (wr_i) begin
        case (grp_i)
          GRP_CNF: cnf_q <= merge(cnf_q, sel, val, msk_i);
          GRP_OE:  oe_q  <= merge(oe_q,  sel, val, msk_i);
          GRP_OUT: out_q <= merge(out_q, sel, val, msk_i);
          GRP_ENB: enb_q <= merge(enb_q, sel, val, msk_i);
          GRP_TYP: begin
            if (msk_i) typ_q[PINS-1:0] <= merge(typ_q[PINS-1:0], sel, val, 1'b1);
            else       typ_q <= wdata_i;
          end
          default: ;
        endcase
      end
    end
  end

  assign cnf_o  = cnf_q;
  assign oe_o   = oe_q;
  assign out_o  = out_q;
  assign sta_o  = sta_q;
  assign enb_o  = enb_q;
  assign typ_o  = typ_q;
  assign pend_o = |(sta_q & enb_q);

  // R3: unselected pins keep their output value across a masked write
  p_mask_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && msk_i && grp_i == GRP_OUT) |=> (((out_q ^ $past(out_q)) & ~$past(sel)) == '0));

  // R9: a clear without a coincident edge drops edge-mode status
  p_clear_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sta_q & $past(clr & edge_m & ~evt)) == '0));

  // R10: a detected edge always leaves status set
  p_evt_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~sta_q & $past(evt & edge_m)) == '0));

  // R7: level-mode status tracks the active level of the previous cycle
  p_level_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((sta_q ^ $past(act)) & ~$past(edge_m)) == '0));
endmodule

// File: rtl/gpio_bank32.sv
module gpio_bank32
  import gpio_pkg::*;
#(
  parameter  int PORTS = 4,
  parameter  int PINS  = 8,
  parameter  int DW    = 32,
  localparam int PW    = $clog2(PORTS),
  localparam int AW    = PW + GRP_W + 3,
  localparam int NP    = PORTS * PINS,
  localparam int TW    = 3 * PINS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_we_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic [NP-1:0] pad_in_i,
  output logic [NP-1:0] pad_out_o,
  output logic [NP-1:0] pad_oe_o,
  output logic          irq_o
);
  logic [PW-1:0]   port_idx;
  grp_e            grp;
  logic            msk;
  logic [NP-1:0]   pin_s;
  logic [PINS-1:0] cnf_a [PORTS];
  logic [PINS-1:0] oe_a  [PORTS];
  logic [PINS-1:0] out_a [PORTS];
  logic [PINS-1:0] sta_a [PORTS];
  logic [PINS-1:0] enb_a [PORTS];
  logic [PINS-1:0] in_a  [PORTS];
  logic [TW-1:0]   typ_a [PORTS];
  logic [PORTS-1:0] pend;
  logic            unused_bits;

  assign port_idx    = reg_addr_i[PW+1:2];
  assign grp         = grp_e'(reg_addr_i[PW+GRP_W+1:PW+2]);
  assign msk         = reg_addr_i[AW-1];
  assign unused_bits = ^{reg_addr_i[1:0], reg_wdata_i[DW-1:TW]};

  gpio_sync #(.W(NP)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pin_s)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    gpio_port #(.PINS(PINS)) u_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (reg_we_i && port_idx == PW'(p)),
      .msk_i   (msk),
      .grp_i   (grp),
      .wdata_i (reg_wdata_i[TW-1:0]),
      .pin_i   (pin_s[p*PINS +: PINS]),
      .cnf_o   (cnf_a[p]),
      .oe_o    (oe_a[p]),
      .out_o   (out_a[p]),
      .sta_o   (sta_a[p]),
      .enb_o   (enb_a[p]),
      .typ_o   (typ_a[p]),
      .pend_o  (pend[p])
    );
    assign in_a[p]                    = pin_s[p*PINS +: PINS];
    assign pad_out_o[p*PINS +: PINS]  = out_a[p];
    assign pad_oe_o[p*PINS +: PINS]   = cnf_a[p] & oe_a[p];
  end

  assign irq_o = |pend;

  always_comb begin
    reg_rdata_o = '0;
    case (grp)
      GRP_CNF: reg_rdata_o[PINS-1:0] = cnf_a[port_idx];
      GRP_OE:  reg_rdata_o[PINS-1:0] = oe_a[port_idx];
      GRP_OUT: reg_rdata_o[PINS-1:0] = out_a[port_idx];
      GRP_IN:  reg_rdata_o[PINS-1:0] = in_a[port_idx];
      GRP_STA: reg_rdata_o[PINS-1:0] = sta_a[port_idx];
      GRP_ENB: reg_rdata_o[PINS-1:0] = enb_a[port_idx];
      GRP_TYP: reg_rdata_o[TW-1:0]   = typ_a[port_idx];
      default: ;
    endcase
  end
endmodule

// File: tb/tb_gpio_bank32.sv
module tb_gpio_bank32;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;

  always #10 clk = ~clk;

  gpio_bank32 dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .irq_o(irq)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_cnf, m_oe, m_out, m_enb, m_sta, m_s1, m_s2, m_prev;
  logic [23:0] m_typ [4];

  function automatic logic mbit(input logic old, input logic s, input logic v, input logic m);
    if (!m) return v;
    return s ? v : old;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnf = '0; m_oe = '0; m_out = '0; m_enb = '0; m_sta = '0;
      m_s1 = '0; m_s2 = '0; m_prev = '0;
      for (int p = 0; p < 4; p++) m_typ[p] = '0;
    end else begin
      logic [31:0] nsta;
      int prt, grp;
      logic msk;
      nsta = m_sta;
      prt = int'(addr[3:2]);
      grp = int'(addr[6:4]);
      msk = addr[7];
      for (int i = 0; i < 32; i++) begin
        int p, b;
        logic pol, edg, bth, rise, fall, hit;
        p = i / 8; b = i % 8;
        pol = m_typ[p][b]; edg = m_typ[p][b+8]; bth = m_typ[p][b+16];
        rise = m_s2[i] && !m_prev[i];
        fall = !m_s2[i] && m_prev[i];
        hit = bth ? (rise || fall) : (pol ? rise : fall);
        if (!edg) nsta[i] = (m_s2[i] == pol);
        else if (hit) nsta[i] = 1'b1;
        else if (we && prt == p && grp == 7 && !msk && wdata[b]) nsta[i] = 1'b0;
        else if (we && prt == p && grp == 4 && msk && wdata[b+8]) nsta[i] = wdata[b];
      end
      if (we) begin
        for (int b = 0; b < 8; b++) begin
          int i;
          i = prt * 8 + b;
          case (grp)
            0: m_cnf[i] = mbit(m_cnf[i], wdata[b+8], wdata[b], msk);
            1: m_oe[i]  = mbit(m_oe[i],  wdata[b+8], wdata[b], msk);
            2: m_out[i] = mbit(m_out[i], wdata[b+8], wdata[b], msk);
            5: m_enb[i] = mbit(m_enb[i], wdata[b+8], wdata[b], msk);
            6: if (msk && wdata[b+8]) m_typ[prt][b] = wdata[b];
            default: ;
          endcase
        end
        if (grp == 6 && !msk) m_typ[prt] = wdata[23:0];
      end
      m_sta = nsta;
      m_prev = m_s2;
      m_s2 = m_s1;
      m_s1 = pad_in;
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    int prt;
    prt = int'(a[3:2]);
    case (a[6:4])
      3'd0: return {24'h0, m_cnf[prt*8 +: 8]};
      3'd1: return {24'h0, m_oe[prt*8 +: 8]};
      3'd2: return {24'h0, m_out[prt*8 +: 8]};
      3'd3: return {24'h0, m_s2[prt*8 +: 8]};
      3'd4: return {24'h0, m_sta[prt*8 +: 8]};
      3'd5: return {24'h0, m_enb[prt*8 +: 8]};
      3'd6: return {8'h0, m_typ[prt]};
      default: return 32'h0;
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(pad_out, m_out, "R4 pad_out vs model");
      chk(pad_oe, m_cnf & m_oe, "R4 pad_oe vs model");
      chk({31'h0, irq}, {31'h0, |(m_sta & m_enb)}, "R12 irq vs model");
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_lit(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a; we = 1'b0;
    #2;
    chk(rdata, exp, tag);
    chk(rdata, m_read(a), {tag, " model"});
  endtask

  task automatic set_pad(input logic [31:0] v);
    @(negedge clk);
    pad_in = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk({31'h0, irq}, 32'h0, "R1 irq after reset");
    chk(pad_oe, 32'h0, "R1 pad_oe after reset");
    rd_lit(8'h00, 32'h0, "R1 cnf");
    rd_lit(8'h14, 32'h0, "R1 oe");
    rd_lit(8'h28, 32'h0, "R1 out");
    rd_lit(8'h5C, 32'h0, "R1 enb");
    rd_lit(8'h64, 32'h0, "R1 typ");

    // R2 decode and widths
    wr(8'h04, 32'h1234_5678);
    rd_lit(8'h04, 32'h78, "R2 cnf port1 low byte");
    rd_lit(8'h00, 32'h0, "R2 other port untouched");
    rd_lit(8'h84, 32'h78, "R3 masked alias read");
    wr(8'h64, 32'hFFAB_CDEF);
    rd_lit(8'h64, 32'h00AB_CDEF, "R2 typ 24 bits");
    rd_lit(8'h74, 32'h0, "R2 clear reads zero");
    wr(8'h64, 32'h0);
    wr(8'h04, 32'h0);

    // R3 masked write
    wr(8'h20, 32'hA5);
    wr(8'hA0, 32'h3C14);
    rd_lit(8'h20, 32'h95, "R3 masked out merge");
    rd_lit(8'hA0, 32'h95, "R3 masked out alias read");

    // R4 pad drive
    wr(8'h00, 32'h0F);
    wr(8'h10, 32'hFF);
    idle(1);
    chk({24'h0, pad_oe[7:0]}, 32'h0F, "R4 oe gated by cnf");
    chk({24'h0, pad_out[7:0]}, 32'h95, "R4 pad_out");

    // R5 input sync
    set_pad(32'h5A00_0000);
    rd_lit(8'h3C, 32'h00, "R5 one clock not yet");
    rd_lit(8'h3C, 32'h5A, "R5 after two clocks");
    wr(8'h3C, 32'hFF);
    wr(8'hBC, 32'hFFFF);
    rd_lit(8'h3C, 32'h5A, "R5 input write ignored");

    // R7 level-high pin1 port3
    wr(8'h6C, 32'h000002);
    wr(8'hDC, 32'h0202);
    idle(2);
    chk({31'h0, irq}, 32'h1, "R7 level high irq");
    wr(8'h7C, 32'h02);
    rd_lit(8'h4C, 32'hA7, "R7 clear no lasting effect");
    set_pad(32'h5800_0000);
    idle(4);
    chk({31'h0, irq}, 32'h0, "R7 level released");
    wr(8'h5C, 32'h00);

    // R8 rising edge pin1 port2
    wr(8'h68, 32'h000202);
    wr(8'h58, 32'h02);
    set_pad(32'h5802_0000);
    set_pad(32'h5800_0000);
    idle(4);
    chk({31'h0, irq}, 32'h1, "R8 edge held");
    rd_lit(8'h48, 32'hFF, "R8 status held");
    wr(8'h78, 32'h02);
    rd_lit(8'h48, 32'hFD, "R9 clear");
    chk({31'h0, irq}, 32'h0, "R9 irq after clear");
    set_pad(32'h5802_0000);
    idle(4);
    wr(8'h78, 32'hFD);
    rd_lit(8'h48, 32'hFF, "R9 zero bits ignored");
    wr(8'hF8, 32'hFFFF);
    rd_lit(8'h48, 32'hFF, "R9 masked clear ignored");

    // R6 falling via masked type write
    wr(8'hE8, 32'h0200);
    rd_lit(8'h68, 32'h000200, "R6 masked type polarity only");
    wr(8'h78, 32'h02);
    set_pad(32'h5800_0000);
    idle(4);
    rd_lit(8'h48, 32'hFF, "R6 falling detected");
    wr(8'h78, 32'h02);
    set_pad(32'h5802_0000);
    idle(4);
    rd_lit(8'h48, 32'hFD, "R6 rising ignored when falling");

    // R6 both edges, then R10 clear collides with edge
    wr(8'h68, 32'h020200);
    set_pad(32'h5800_0000);
    idle(4);
    rd_lit(8'h48, 32'hFF, "R6 both edges falling");
    set_pad(32'h5802_0000);
    repeat (2) @(posedge clk);
    wr(8'h78, 32'h02);
    rd_lit(8'h48, 32'hFF, "R10 edge wins over clear");
    wr(8'h78, 32'h02);
    rd_lit(8'h48, 32'hFD, "R10 plain clear");

    // R11 status writes
    wr(8'h48, 32'hFF);
    rd_lit(8'h48, 32'hFD, "R11 direct status write ignored");
    wr(8'hC8, 32'h0202);
    rd_lit(8'h48, 32'hFF, "R11 masked status set");
    chk({31'h0, irq}, 32'h1, "R12 irq from masked set");
    wr(8'hC8, 32'h0200);
    rd_lit(8'h48, 32'hFD, "R11 masked status clear");
    chk({31'h0, irq}, 32'h0, "R12 irq low");

    // R12 enable alone on another port
    wr(8'h50, 32'h01);
    idle(1);
    chk({31'h0, irq}, 32'h1, "R12 port0 level-low pending");
    wr(8'hD0, 32'h0100);
    idle(1);
    chk({31'h0, irq}, 32'h0, "R12 masked enable off");

    idle(2);
    finish_run();
  end
endmodule